// File: doc/BRIEF.md
# Crosspoint Routing Configuration Slave (SMBus)

This block is the management-side register interface of a small 4x4 signal routing device. It is an SMBus slave that runs on an oversampled system clock. It synchronises the bus clock and data lines, detects START and STOP conditions, and decodes single-byte register writes and register reads that use a repeated START. It drives the data line only through an active-low output enable, for an open-drain pad.

The register set is small and sparse. A routing register picks the source input for each of the four outputs. A control register holds per-output enables, a loss-of-signal monitor enable, a soft power bit and two spare writable bits. A read-only status register reports signal presence on each input. The contents of the routing and control registers are presented continuously on parallel outputs to the datapath. The slave address has a fixed upper part and a lower part taken from four strap pins. A mode-enable input keeps the whole block in its reset state while it is low, so each toggle of that input restores the defaults.

Top module: `smb_xbar_cfg`

## Requirements
- R1: The slave address is 7 bits: binary 101 in bits [6:4] and the strap inputs in bits [3:0], with strap[0] as the LSB. The slave acknowledges only a matching address. After a mismatch it acknowledges nothing and leaves SDA released until the next START.
- R2: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. A START in any state, including in the middle of a transaction, begins a new address phase.
- R3: In a write (address with R/W=0, register byte, data byte), the slave pulls the ninth bit low after each of the three bytes. The data byte then lands in the addressed register.
- R4: SDA is driven only as an active-low output enable (sda_oe=1 pulls the line low). The enable changes only while SCL is low, and it is 0 when the bus is idle.
- R5: In a read (address with W, register byte, repeated START, address with R/W=1), the slave acknowledges the address. It then drives the selected register MSB first, and releases SDA for the master's NACK.
- R6: Register 0x00 is the routing register, reset value 0x00. Bits [1:0], [3:2], [5:4] and [7:6] select the source for outputs 0, 1, 2 and 3 respectively. The register is mirrored on route_sel.
- R7: Register 0x03 is the control register, reset value 0x0F. Bits [3:0] are the per-output enables, bits [5:4] are spare and writable, bit 6 is the monitor enable and bit 7 is the soft power bit. All eight bits are mirrored on ctrl_reg.
- R8: Register 0x04 is read-only and returns {4'b0000, sig_ok[3:0]}, where a 1 means a valid signal on that input. A write to it is acknowledged and has no effect.
- R9: A write to any other register address is acknowledged and discarded, and leaves registers 0x00 and 0x03 unchanged. A read of any other address returns 0x00.
- R10: While mode_en is low, every register is held at its reset value and sda_oe is 0. The registers come back at their reset values when mode_en rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Management mode enable; low holds the block in reset |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| addr_strap | input | 4 | Low four bits of the slave address |
| sig_ok | input | 4 | Per-input signal-present flags |
| route_sel | output | 8 | Routing register contents |
| ctrl_reg | output | 8 | Control register contents |

## Verification
A bit counter or shift register that is off by one shows up at the ports within a single byte. The acknowledge moves to the wrong SCL period, so the master sees NACK on its next sample, or the read data comes back shifted by a bit. A wrong state after an address mismatch or a START shows up in the same way: an acknowledge that should not be there, or one that is missing, on the next ninth bit. A corrupted register or a wrong reset value appears on route_sel or ctrl_reg a few system clocks after the STOP or after the mode toggle.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_W    = 7;
  localparam int unsigned STRAP_W   = 4;
  localparam int unsigned LANES     = 4;
  localparam logic [2:0]  ADDR_HI   = 3'b101;

  localparam logic [BYTE_W-1:0] REG_ROUTE = 8'h00;
  localparam logic [BYTE_W-1:0] REG_CTRL  = 8'h03;
  localparam logic [BYTE_W-1:0] REG_SIG   = 8'h04;
  localparam logic [BYTE_W-1:0] CTRL_RST  = 8'h0F;

  typedef enum logic [3:0] {
    LK_IDLE,
    LK_ADDR,
    LK_AACK,
    LK_REG,
    LK_RACK,
    LK_WDAT,
    LK_WACK,
    LK_RDAT,
    LK_SKIP
  } link_state_t;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic        RSTVAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain[s] <= {WIDTH{RSTVAL}};
        end else begin
          if (s == 0) chain[s] <= d;
          else        chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/smb_link.sv
module smb_link
  import smbcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] reg_ptr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_en,
  output logic              sda_oe
);
  link_state_t       st_q, st_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic              rw_q, rw_d;
  logic              oe_q, oe_d;
  logic              wr_q, wr_d;
  logic              scl_q, sda_q;

  logic scl_rise, scl_fall, cond_start, cond_stop, byte_done;

  assign scl_rise   =  scl_s & ~scl_q;
  assign scl_fall   = ~scl_s &  scl_q;
  assign cond_start =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign cond_stop  =  scl_s &  scl_q & ~sda_q &  sda_s;
  assign byte_done  =  scl_fall && (cnt_q == 4'd8);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sr_d  = sr_q;
    tx_d  = tx_q;
    ptr_d = ptr_q;
    rw_d  = rw_q;
    oe_d  = oe_q;
    wr_d  = 1'b0;
    if (cond_start) begin
      st_d  = LK_ADDR;
      cnt_d = 4'd0;
      oe_d  = 1'b0;
    end else if (cond_stop) begin
      st_d  = LK_IDLE;
      oe_d  = 1'b0;
    end else begin
      unique case (st_q)
        LK_ADDR, LK_REG, LK_WDAT: begin
          if (scl_rise) begin
            sr_d  = {sr_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end
          if (byte_done) begin
            cnt_d = 4'd0;
            if (st_q == LK_ADDR) begin
              if (sr_q[BYTE_W-1:1] == dev_addr) begin
                rw_d = sr_q[0];
                oe_d = 1'b1;
                st_d = LK_AACK;
              end else begin
                st_d = LK_SKIP;
              end
            end else if (st_q == LK_REG) begin
              ptr_d = sr_q;
              oe_d  = 1'b1;
              st_d  = LK_RACK;
            end else begin
              wr_d = 1'b1;
              oe_d = 1'b1;
              st_d = LK_WACK;
            end
          end
        end
        LK_AACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              tx_d  = rd_data;
              oe_d  = ~rd_data[BYTE_W-1];
              cnt_d = 4'd0;
              st_d  = LK_RDAT;
            end else begin
              oe_d = 1'b0;
              st_d = LK_REG;
            end
          end
        end
        LK_RACK: begin
          if (scl_fall) begin
            oe_d = 1'b0;
            st_d = LK_WDAT;
          end
        end
        LK_WACK: begin
          if (scl_fall) begin
            oe_d = 1'b0;
            st_d = LK_SKIP;
          end
        end
        LK_RDAT: begin
          if (scl_rise) cnt_d = cnt_q + 4'd1;
          if (byte_done) begin
            oe_d = 1'b0;
            st_d = LK_SKIP;
          end else if (scl_fall) begin
            tx_d = {tx_q[BYTE_W-2:0], 1'b0};
            oe_d = ~tx_q[BYTE_W-2];
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LK_IDLE;
      cnt_q <= 4'd0;
      sr_q  <= '0;
      tx_q  <= '0;
      ptr_q <= '0;
      rw_q  <= 1'b0;
      oe_q  <= 1'b0;
      wr_q  <= 1'b0;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else if (clr) begin
      st_q  <= LK_IDLE;
      cnt_q <= 4'd0;
      sr_q  <= '0;
      tx_q  <= '0;
      ptr_q <= '0;
      rw_q  <= 1'b0;
      oe_q  <= 1'b0;
      wr_q  <= 1'b0;
      scl_q <= scl_s;
      sda_q <= sda_s;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
      tx_q  <= tx_d;
      ptr_q <= ptr_d;
      rw_q  <= rw_d;
      oe_q  <= oe_d;
      wr_q  <= wr_d;
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign reg_ptr = ptr_q;
  assign wr_data = sr_q;
  assign wr_en   = wr_q;
  assign sda_oe  = oe_q;
endmodule

// File: rtl/smb_regs.sv
module smb_regs
  import smbcfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [BYTE_W-1:0]  addr,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic [LANES-1:0]   sig_ok,
  output logic [BYTE_W-1:0]  rdata,
  output logic [BYTE_W-1:0]  route_q,
  output logic [BYTE_W-1:0]  ctrl_q
);
  logic [BYTE_W-1:0] route_d, ctrl_d;
  logic              route_we, ctrl_we;

  assign route_we = wr_en && (addr == REG_ROUTE);
  assign ctrl_we  = wr_en && (addr == REG_CTRL);

  always_comb begin
    route_d = route_we ? wdata : route_q;
    ctrl_d  = ctrl_we  ? wdata : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      ctrl_q  <= CTRL_RST;
    end else if (clr) begin
      route_q <= '0;
      ctrl_q  <= CTRL_RST;
    end else begin
      route_q <= route_d;
      ctrl_q  <= ctrl_d;
    end
  end

  always_comb begin
    unique case (addr)
      REG_ROUTE: rdata = route_q;
      REG_CTRL:  rdata = ctrl_q;
      REG_SIG:   rdata = {{(BYTE_W-LANES){1'b0}}, sig_ok};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/smb_xbar_cfg.sv
module smb_xbar_cfg
  import smbcfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_en,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] addr_strap,
  input  logic [LANES-1:0]   sig_ok,
  output logic [BYTE_W-1:0]  route_sel,
  output logic [BYTE_W-1:0]  ctrl_reg
);
  logic [1:0]        bus_s;
  logic              scl_s, sda_s, mode_ok, clr;
  logic [LANES-1:0]  sig_s;
  logic [BYTE_W-1:0] reg_ptr, wr_data, rd_data;
  logic              wr_en;
  logic [ADDR_W-1:0] dev_addr;

  smb_sync #(.WIDTH(2), .STAGES(2), .RSTVAL(1'b1)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
  );
  smb_sync #(.WIDTH(1), .STAGES(2), .RSTVAL(1'b0)) u_mode_sync (
    .clk(clk), .rst_n(rst_n), .d(mode_en), .q(mode_ok)
  );
  smb_sync #(.WIDTH(LANES), .STAGES(2), .RSTVAL(1'b0)) u_sig_sync (
    .clk(clk), .rst_n(rst_n), .d(sig_ok), .q(sig_s)
  );

  assign scl_s    = bus_s[1];
  assign sda_s    = bus_s[0];
  assign clr      = ~mode_ok;
  assign dev_addr = {ADDR_HI, addr_strap};

  smb_link u_link (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .scl_s(scl_s), .sda_s(sda_s), .dev_addr(dev_addr),
    .rd_data(rd_data), .reg_ptr(reg_ptr), .wr_data(wr_data),
    .wr_en(wr_en), .sda_oe(sda_oe)
  );

  smb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(wr_en), .addr(reg_ptr), .wdata(wr_data), .sig_ok(sig_s),
    .rdata(rd_data), .route_q(route_sel), .ctrl_q(ctrl_reg)
  );
endmodule

// File: rtl/smb_xbar_cfg_chk.sv
module smb_xbar_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_ok,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       wr_en,
  input logic [7:0] route_sel,
  input logic [7:0] ctrl_reg
);
  a_r4_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ok && $past(mode_ok) && (sda_oe != $past(sda_oe))) |-> !scl_s);

  a_r10_mode_low_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok |=> (route_sel == 8'h00 && ctrl_reg == 8'h0F && !sda_oe));

  a_r6_route_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ok && $past(mode_ok) && (route_sel != $past(route_sel))) |-> $past(wr_en));

  a_r7_ctrl_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ok && $past(mode_ok) && (ctrl_reg != $past(ctrl_reg))) |-> $past(wr_en));

  a_r3_write_in_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !scl_s);
endmodule

bind smb_xbar_cfg smb_xbar_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_ok(mode_ok), .scl_s(scl_s),
  .sda_oe(sda_oe), .wr_en(wr_en), .route_sel(route_sel), .ctrl_reg(ctrl_reg)
);

// File: tb/smb_xbar_cfg_tb.sv
module smb_xbar_cfg_tb;
  localparam int Q = 6;
  localparam logic [3:0] STRAP = 4'b0110;
  localparam logic [6:0] MYADDR = {3'b101, STRAP};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_en = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [3:0] sig_ok = 4'b0000;
  logic sda_oe, sda_line;
  logic [7:0] route_sel, ctrl_reg;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_route, m_ctrl;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  smb_xbar_cfg u_dut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .addr_strap(STRAP), .sig_ok(sig_ok),
    .route_sel(route_sel), .ctrl_reg(ctrl_reg)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    case (a)
      8'h00:   return m_route;
      8'h03:   return m_ctrl;
      8'h04:   return {4'b0000, sig_ok};
      default: return 8'h00;
    endcase
  endfunction

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic bit_io(input logic b, output logic got);
    sda_m = b; qw(); scl_m = 1'b1; qw(); got = sda_line; qw(); scl_m = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) bit_io(d[i], g);
    bit_io(1'b1, g);
    ack = ~g;
  endtask

  task automatic get_byte(output logic [7:0] d);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, g);
      d[i] = g;
    end
    bit_io(1'b1, g);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                          output logic [2:0] acks);
    bus_start();
    put_byte({a, 1'b0}, acks[2]);
    put_byte(r, acks[1]);
    put_byte(d, acks[0]);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] r, output logic [7:0] d, output logic [1:0] acks);
    logic a0;
    bus_start();
    put_byte({MYADDR, 1'b0}, a0);
    put_byte(r, acks[0]);
    bus_start();
    put_byte({MYADDR, 1'b1}, acks[1]);
    get_byte(d);
    bus_stop();
    acks[0] = acks[0] & a0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] wa;
    logic [1:0] ra;
    logic [7:0] rd, r, d;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    m_route = 8'h00;
    m_ctrl  = 8'h0F;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check("R6 reset route", route_sel, 8'h00);
    check("R7 reset ctrl", ctrl_reg, 8'h0F);
    check("R4 idle oe", {7'b0, sda_oe}, 8'h00);

    do_write(MYADDR, 8'h00, 8'hE4, wa);
    m_route = 8'hE4;
    check("R3 write acks", {5'b0, wa}, 8'h07);
    repeat (4) @(negedge clk);
    check("R6 route field map", route_sel, 8'hE4);

    do_write(MYADDR, 8'h03, 8'hF5, wa);
    m_ctrl = 8'hF5;
    repeat (4) @(negedge clk);
    check("R7 ctrl all bits", ctrl_reg, 8'hF5);

    sig_ok = 4'b1010;
    repeat (4) @(negedge clk);
    do_read(8'h04, rd, ra);
    check("R5 read acks", {6'b0, ra}, 8'h03);
    check("R8 sig read", rd, 8'h0A);

    do_write(MYADDR, 8'h04, 8'hFF, wa);
    check("R8 write ack", {5'b0, wa}, 8'h07);
    do_read(8'h04, rd, ra);
    check("R8 write ignored", rd, 8'h0A);

    do_write(MYADDR, 8'h07, 8'h5A, wa);
    check("R9 unimpl ack", {5'b0, wa}, 8'h07);
    repeat (4) @(negedge clk);
    check("R9 route kept", route_sel, m_route);
    check("R9 ctrl kept", ctrl_reg, m_ctrl);
    do_read(8'h07, rd, ra);
    check("R9 unimpl read", rd, 8'h00);

    do_write(MYADDR ^ 7'h01, 8'h00, 8'h11, wa);
    check("R1 mismatch no ack", {5'b0, wa}, 8'h00);
    repeat (4) @(negedge clk);
    check("R1 mismatch no write", route_sel, m_route);

    // R2: abort a write with a START, then a fresh write must work
    bus_start();
    put_byte({MYADDR, 1'b0}, wa[2]);
    put_byte(8'h00, wa[1]);
    do_write(MYADDR, 8'h00, 8'h1B, wa);
    m_route = 8'h1B;
    check("R2 restart acks", {5'b0, wa}, 8'h07);
    repeat (4) @(negedge clk);
    check("R2 restart write", route_sel, 8'h1B);

    mode_en = 1'b0;
    repeat (10) @(negedge clk);
    check("R10 low route", route_sel, 8'h00);
    check("R10 low ctrl", ctrl_reg, 8'h0F);
    mode_en = 1'b1;
    m_route = 8'h00;
    m_ctrl  = 8'h0F;
    repeat (10) @(negedge clk);
    do_read(8'h03, rd, ra);
    check("R10 ctrl after toggle", rd, 8'h0F);

    for (int it = 0; it < 50; it++) begin
      case ($urandom % 5)
        0: r = 8'h00;
        1: r = 8'h03;
        2: r = 8'h04;
        3: r = 8'h01;
        default: r = 8'($urandom % 256);
      endcase
      d = 8'($urandom);
      sig_ok = 4'($urandom);
      if ($urandom % 2 == 0) begin
        do_write(MYADDR, r, d, wa);
        if (r == 8'h00) m_route = d;
        if (r == 8'h03) m_ctrl = d;
        check("R3 rand write acks", {5'b0, wa}, 8'h07);
        repeat (4) @(negedge clk);
        check("R6 rand route", route_sel, m_route);
        check("R7 rand ctrl", ctrl_reg, m_ctrl);
      end else begin
        repeat (4) @(negedge clk);
        do_read(r, rd, ra);
        check("R5 rand read", rd, model_rd(r));
      end
      check("R4 oe idle", {7'b0, sda_oe}, 8'h00);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule